// File: doc/BRIEF.md
# Carry-Chaining Integer ALU

This block is the arithmetic and logic unit of a small 32-bit pipelined processor core. A 6-bit operation code picks the function. A 2-bit sub-function field splits the shift and sign-extension groups. The operand B input takes either a register value or an immediate that has already been extended upstream. The result and a candidate carry are produced combinationally in the same cycle as the operands.

The block keeps a one-bit carry flag. The flag is loaded from the candidate carry only on add or subtract operations while the flag write-enable is high. It feeds the add-with-carry and subtract-with-borrow operations, so software can chain multi-word arithmetic.

Subtraction is reversed: the unit returns operand B minus operand A. When B carries an immediate, this gives the immediate minus the register.

Top module: `carry_alu`

## Requirements
- R1: Opcode 000000 returns A + B modulo 2^32, and `carry_o` is the carry out of bit 31.
- R2: Opcode 000001 returns A + B + F, where F is the stored flag. `carry_o` is the carry out of that three-term sum.
- R3: Opcode 000010 returns B - A modulo 2^32. `carry_o` is 1 exactly when A > B, taken as unsigned values (a borrow).
- R4: Opcode 000011 returns B - A - F. `carry_o` is 1 exactly when A + F > B, taken as unsigned values.
- R5: Opcodes 000100, 000101 and 000110 return A | B, A & B and A ^ B respectively.
- R6: Opcode 001000 shifts A by B[4:0] only; the upper bits of B are ignored. Sub-function 00 shifts left, 01 shifts right logically and 10 shifts right arithmetically.
- R7: Opcode 001001 returns the low 32 bits of the product A * B.
- R8: Opcode 000111 sign-extends A. With sub-function bit 0 = 0 it extends from A[7:0]; with sub-function bit 0 = 1 it extends from A[15:0].
- R9: For every opcode other than 000000 through 000011, `carry_o` is 0.
- R10: On a rising clock edge, the flag `flag_o` loads `carry_o` when `flag_we_i` is 1 and the opcode is 000000 through 000011. In all other cases it keeps its value.
- R11: A synchronous active-high reset clears `flag_o` to 0.
- R12: Opcodes outside the ten listed above return 0. Opcode 001000 with sub-function 11 also returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Operation code |
| sub_i | input | 2 | Sub-function for shifts and sign extension |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B (register value or extended immediate) |
| flag_we_i | input | 1 | Carry flag write-enable |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Combinational candidate carry or borrow |
| flag_o | output | 1 | Stored carry flag |

## Verification
Two functions can land in the same cycle: a carry-consuming operation reads the stored flag while that same edge rewrites it. The bench provokes this with back-to-back chained operations, such as an add that overflows followed by an add-with-carry, or a subtract that borrows followed by a subtract-with-borrow, with the write-enable held high. The outcome is judged two ways. The second result must use the flag produced by the first operation, and the flag must then hold the second operation's carry. Random runs also interleave non-arithmetic operations while the enable is high, and the flag must stay unchanged through them.

// File: rtl/calu_pkg.sv
package calu_pkg;
  localparam logic [5:0] OP_ADD   = 6'b000000;
  localparam logic [5:0] OP_ADC   = 6'b000001;
  localparam logic [5:0] OP_SUB   = 6'b000010;
  localparam logic [5:0] OP_SBB   = 6'b000011;
  localparam logic [5:0] OP_OR    = 6'b000100;
  localparam logic [5:0] OP_AND   = 6'b000101;
  localparam logic [5:0] OP_XOR   = 6'b000110;
  localparam logic [5:0] OP_SEXT  = 6'b000111;
  localparam logic [5:0] OP_SHIFT = 6'b001000;
  localparam logic [5:0] OP_MUL   = 6'b001001;

  localparam logic [1:0] SH_LEFT  = 2'b00;
  localparam logic [1:0] SH_LOGR  = 2'b01;
  localparam logic [1:0] SH_ARIR  = 2'b10;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_BITS  = 2'd1,
    GRP_SHEXT = 2'd2,
    GRP_NONE  = 2'd3
  } calu_grp_e;
endpackage

// File: rtl/calu_addsub.sv
module calu_addsub #(
  parameter int W = 32
) (
  input  logic [5:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         flag,
  output logic         hit,
  output logic [W-1:0] res,
  output logic         cout
);
  import calu_pkg::*;
  localparam int XW = W + 1;

  logic         use_flag;
  logic         is_sub;
  logic [XW-1:0] cin_x;
  logic [XW-1:0] sum_x;
  logic [XW-1:0] dif_x;

  always_comb begin
    hit      = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB);
    use_flag = (op == OP_ADC) || (op == OP_SBB);
    is_sub   = (op == OP_SUB) || (op == OP_SBB);
    cin_x    = {{W{1'b0}}, use_flag & flag};
    sum_x    = {1'b0, a} + {1'b0, b} + cin_x;
    dif_x    = {1'b0, b} - {1'b0, a} - cin_x;
    res      = is_sub ? dif_x[W-1:0] : sum_x[W-1:0];
    cout     = hit & (is_sub ? dif_x[W] : sum_x[W]);
  end
endmodule

// File: rtl/calu_bitmul.sv
module calu_bitmul #(
  parameter int W = 32
) (
  input  logic [5:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit,
  output logic [W-1:0] res
);
  import calu_pkg::*;

  always_comb begin
    hit = 1'b1;
    unique case (op)
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_MUL:  res = a * b;
      default: begin
        res = '0;
        hit = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/calu_shext.sv
module calu_shext #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [5:0]    op,
  input  logic [1:0]    sub,
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  output logic          hit,
  output logic [W-1:0]  res
);
  import calu_pkg::*;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [W-1:0] ext_b;
  logic [W-1:0] ext_h;

  always_comb begin
    ext_b = {{(W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
    ext_h = {{(W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
    hit   = 1'b0;
    res   = '0;
    if (op == OP_SHIFT) begin
      hit = 1'b1;
      case (sub)
        SH_LEFT: res = a << amt;
        SH_LOGR: res = a >> amt;
        SH_ARIR: res = W'($signed(a) >>> amt);
        default: res = '0;
      endcase
    end else if (op == OP_SEXT) begin
      hit = 1'b1;
      res = sub[0] ? ext_h : ext_b;
    end
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [5:0]   op_i,
  input  logic [1:0]   sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_we_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         flag_o
);
  import calu_pkg::*;
  localparam int SW = $clog2(W);

  logic         as_hit, bm_hit, se_hit;
  logic [W-1:0] as_res, bm_res, se_res;
  logic         as_cout;
  calu_grp_e    grp;

  calu_addsub #(.W(W)) u_addsub (
    .op(op_i), .a(a_i), .b(b_i), .flag(flag_o),
    .hit(as_hit), .res(as_res), .cout(as_cout)
  );

  calu_bitmul #(.W(W)) u_bitmul (
    .op(op_i), .a(a_i), .b(b_i), .hit(bm_hit), .res(bm_res)
  );

  calu_shext #(.W(W), .SW(SW)) u_shext (
    .op(op_i), .sub(sub_i), .a(a_i), .amt(b_i[SW-1:0]),
    .hit(se_hit), .res(se_res)
  );

  always_comb begin
    if (as_hit)      grp = GRP_ARITH;
    else if (bm_hit) grp = GRP_BITS;
    else if (se_hit) grp = GRP_SHEXT;
    else             grp = GRP_NONE;
    case (grp)
      GRP_ARITH: result_o = as_res;
      GRP_BITS:  result_o = bm_res;
      GRP_SHEXT: result_o = se_res;
      default:   result_o = '0;
    endcase
    carry_o = as_cout;
  end

  always_ff @(posedge clk) begin
    if (rst)                   flag_o <= 1'b0;
    else if (flag_we_i && as_hit) flag_o <= as_cout;
  end
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [5:0]   op_i,
  input logic [1:0]   sub_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         flag_we_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         flag_o
);
  logic arith_op;
  assign arith_op = (op_i[5:2] == 4'b0000);

  assert_add_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (op_i == 6'b000000) |-> ({carry_o, result_o} == {1'b0, a_i} + {1'b0, b_i}));

  assert_xor_back_R5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 6'b000110) |-> ((result_o ^ b_i) == a_i));

  assert_byte_ext_R8: assert property (@(posedge clk) disable iff (rst)
    (op_i == 6'b000111 && !sub_i[0]) |->
      ((result_o[W-1:8] == '0) || (&result_o[W-1:7])));

  assert_no_carry_R9: assert property (@(posedge clk) disable iff (rst)
    !arith_op |-> !carry_o);

  assert_flag_load_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && arith_op) |=> (flag_o == $past(carry_o)));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(flag_we_i && arith_op) |=> $stable(flag_o));

  assert_flag_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !flag_o);
endmodule

bind carry_alu carry_alu_chk #(.W(W)) chk (
  .clk(clk), .rst(rst), .op_i(op_i), .sub_i(sub_i), .a_i(a_i), .b_i(b_i),
  .flag_we_i(flag_we_i), .result_o(result_o), .carry_o(carry_o), .flag_o(flag_o)
);

// File: tb/tb_carry_alu.sv
module tb_carry_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  op;
  logic [1:0]  sub;
  logic [31:0] a, b;
  logic        we;
  logic [31:0] result;
  logic        carry, flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit mflag = 0;

  always #4 clk = ~clk;

  carry_alu dut (
    .clk(clk), .rst(rst), .op_i(op), .sub_i(sub), .a_i(a), .b_i(b),
    .flag_we_i(we), .result_o(result), .carry_o(carry), .flag_o(flag)
  );

  function automatic logic [32:0] model(input logic [5:0] o, input logic [1:0] s,
                                        input logic [31:0] x, input logic [31:0] y,
                                        input logic f);
    logic [32:0] t;
    logic [63:0] p;
    case (o)
      6'd0: t = {1'b0, x} + {1'b0, y};
      6'd1: t = {1'b0, x} + {1'b0, y} + {32'd0, f};
      6'd2: begin t[31:0] = y - x; t[32] = (x > y); end
      6'd3: begin t[31:0] = y - x - {31'd0, f}; t[32] = ({1'b0, x} + {32'd0, f}) > {1'b0, y}; end
      6'd4: t = {1'b0, x | y};
      6'd5: t = {1'b0, x & y};
      6'd6: t = {1'b0, x ^ y};
      6'd7: t = s[0] ? {1'b0, {16{x[15]}}, x[15:0]} : {1'b0, {24{x[7]}}, x[7:0]};
      6'd8: case (s)
              2'd0: t = {1'b0, x << y[4:0]};
              2'd1: t = {1'b0, x >> y[4:0]};
              2'd2: t = {1'b0, 32'($signed(x) >>> y[4:0])};
              default: t = 33'd0;
            endcase
      6'd9: begin p = {32'd0, x} * {32'd0, y}; t = {1'b0, p[31:0]}; end
      default: t = 33'd0;
    endcase
    return t;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [5:0] o, input logic [1:0] s,
                       input logic [31:0] x, input logic [31:0] y, input logic w);
    logic [32:0] e;
    @(negedge clk);
    op = o; sub = s; a = x; b = y; we = w;
    #1;
    e = model(o, s, x, y, mflag);
    check(tag, "result", result, e[31:0]);
    check((o <= 6'd3) ? tag : "R9", "carry", {31'd0, carry}, {31'd0, e[32]});
    @(posedge clk);
    if (w && o <= 6'd3) mflag = e[32];
    #1;
    check("R10", "flag", {31'd0, flag}, {31'd0, mflag});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op = 6'd0; sub = 2'd0; a = 32'd0; b = 32'd0; we = 1'b1;
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1;
    check("R11", "flag after reset", {31'd0, flag}, 32'd0);
    @(negedge clk); rst = 1'b0;

    apply("R1", 6'd0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    apply("R2", 6'd1, 2'd0, 32'h0000_0005, 32'h0000_0007, 1'b1);
    apply("R3", 6'd2, 2'd0, 32'h0000_0009, 32'h0000_0009, 1'b1);
    apply("R3", 6'd2, 2'd0, 32'h0000_000A, 32'h0000_0009, 1'b1);
    apply("R4", 6'd3, 2'd0, 32'h0000_0009, 32'h0000_000A, 1'b1);
    apply("R4", 6'd3, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b1);
    apply("R10", 6'd0, 2'd0, 32'h8000_0000, 32'h8000_0000, 1'b0);
    apply("R10", 6'd5, 2'd0, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1);
    apply("R5", 6'd4, 2'd0, 32'hF0F0_0000, 32'h000F_0F0F, 1'b1);
    apply("R6", 6'd8, 2'd2, 32'h8000_0000, 32'h0000_001F, 1'b1);
    apply("R6", 6'd8, 2'd1, 32'h8000_0000, 32'hFFFF_FFE1, 1'b1);
    apply("R6", 6'd8, 2'd0, 32'h0000_0001, 32'h0000_0021, 1'b1);
    apply("R7", 6'd9, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply("R8", 6'd7, 2'd0, 32'h1234_5680, 32'h0, 1'b1);
    apply("R8", 6'd7, 2'd1, 32'h0000_8000, 32'h0, 1'b1);
    apply("R8", 6'd7, 2'd3, 32'hFFFF_7FFF, 32'h0, 1'b1);
    apply("R12", 6'd8, 2'd3, 32'hDEAD_BEEF, 32'h3, 1'b1);
    apply("R12", 6'h20, 2'd0, 32'hDEAD_BEEF, 32'h3, 1'b1);
    // chained: overflow then add-with-carry on the same flag edge
    apply("R1", 6'd0, 2'd0, 32'hFFFF_FFF0, 32'h0000_0020, 1'b1);
    apply("R2", 6'd1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    apply("R3", 6'd2, 2'd0, 32'h0000_0002, 32'h0000_0001, 1'b1);
    apply("R4", 6'd3, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] o;
      logic [1:0] s;
      int pick = $urandom_range(0, 10);
      o = (pick == 10) ? 6'h2A : 6'(pick);
      s = 2'($urandom_range(0, 3));
      apply((o <= 6'd1) ? "R2" : (o <= 6'd3) ? "R4" : (o <= 6'd6) ? "R5" :
            (o == 6'd7) ? "R8" : (o == 6'd8) ? "R6" : (o == 6'd9) ? "R7" : "R12",
            o, s, $urandom(), ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 40)) : $urandom(),
            1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule